// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This unit collects single-cycle event pulses from up to seven peripheral sources into a pending-flag register, and masks them with an enable register to drive one level-sensitive interrupt line. Software sees both registers through a byte-wide register port. The flag register sits at address 13 and the enable register at address 14. Reading the flag register returns the pending flags plus a computed summary in the top bit. Writing to it acknowledges events: every bit written as 1 is cleared.

The enable register uses a set/clear write scheme so that software can change individual enables without a read-modify-write. The top bit of the written byte chooses the operation, and the low seven bits choose which enables it applies to. Peripherals may also clear their own flag through a dedicated clear request input. Only a configurable subset of flags drives the interrupt line. By default these are bit 2 (shift register) and bit 6 (timer 1). Bit 5 (timer 2) is flagged and enabled but does not raise the line.

Top module: `irq_flag_enable_unit`

## Requirements
- R1: After reset the flags and enables are 0, irq_o is 0, a flag read returns 0x00 and an enable read returns 0x80.
- R2: A pulse on set_i[k] makes flag bit k read as 1 from the clock edge that samples the pulse.
- R3: A write to address 13 clears every flag bit whose written bit in [6:0] is 1 and leaves the others unchanged. Written bit 7 has no effect.
- R4: A pulse on clr_i[k] clears flag bit k.
- R5: When set_i[k] and a clear of bit k (a flag write or clr_i) occur in the same cycle, flag bit k ends up 1.
- R6: A read of address 13 returns the flags in [6:0], and bit 7 is 1 exactly when some flag and its enable are both 1.
- R7: A read of address 14 returns the enables in [6:0], and bit 7 is always 1.
- R8: A write to address 14 with bit 7 = 1 sets the enables selected by 1s in [6:0] and leaves the other enables unchanged.
- R9: A write to address 14 with bit 7 = 0 clears the enables selected by 1s in [6:0] and leaves the other enables unchanged.
- R10: irq_o is registered. It becomes 1 one clock after (flags AND enables) has bit 2 or bit 6 set, and 0 one clock after neither is set. Bit 5 alone never raises irq_o.
- R11: Writes to any other address leave the flags and enables unchanged, and reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe, one byte per cycle |
| addr_i | input | 4 | Register address (13 = flags, 14 = enables) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| set_i | input | 7 | Per-source flag set pulses |
| clr_i | input | 7 | Per-source flag clear requests |
| irq_o | output | 1 | Registered interrupt request level |

## Verification
The assertions assume that set_i, clr_i and the write strobe are synchronous and stable around the rising edge. They also assume that one flag bit may be the target of a set and a clear in the same cycle, and they allow for that case. The bench drives every input on the falling edge and releases it one cycle later. Each pulse therefore lasts exactly one sampling edge, and it deliberately overlaps set and clear on the same bit to cover the priority rule.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned N_SRC    = DATA_W - 1;
  localparam int unsigned ADDR_W   = 4;
  localparam logic [ADDR_W-1:0] FLAG_ADDR = 4'd13;
  localparam logic [ADDR_W-1:0] EN_ADDR   = 4'd14;
  localparam logic [N_SRC-1:0]  IRQ_SRC_MASK = 7'h44;

  typedef logic [N_SRC-1:0] src_vec_t;
  typedef enum logic {EN_CLEAR = 1'b0, EN_SET = 1'b1} en_op_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] hw_clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         flag_q <= 1'b0;
      else if (set_i[b])                   flag_q <= 1'b1;  // set beats clear
      else if (sw_clr_i[b] || hw_clr_i[b]) flag_q <= 1'b0;
    end
    assign flag_o[b] = flag_q;

    a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> flag_o[b]);
    a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((sw_clr_i[b] || hw_clr_i[b]) && !set_i[b]) |=> !flag_o[b]);
    a_r2_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_o[b] && !set_i[b]) |=> !flag_o[b]);
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_unit_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N:0]   wdata_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;
  en_op_e       op;

  assign op = en_op_e'(wdata_i[N]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (we_i) begin
      if (op == EN_SET) en_q <= en_q | wdata_i[N-1:0];
      else              en_q <= en_q & ~wdata_i[N-1:0];
    end
  end
  assign en_o = en_q;

  a_r8_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[N]) |=> ((en_o & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));
  a_r9_clear_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[N]) |=> ((en_o & $past(wdata_i[N-1:0])) == '0));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_o));
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int unsigned N = 7,
  parameter logic [N-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag_i & en_i & MASK);
  end
  assign irq_o = irq_q;

  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(flag_i & en_i & MASK))));
endmodule

// File: rtl/irq_flag_enable_unit.sv
module irq_flag_enable_unit
  import irq_unit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  set_i,
  input  logic [N_SRC-1:0]  clr_i,
  output logic              irq_o
);
  src_vec_t flags, enables, sw_clr;
  logic     flag_sel, en_sel, pending;

  assign flag_sel = (addr_i == FLAG_ADDR);
  assign en_sel   = (addr_i == EN_ADDR);
  assign sw_clr   = (we_i && flag_sel) ? wdata_i[N_SRC-1:0] : '0;
  assign pending  = |(flags & enables);

  irq_flag_bank #(.N(N_SRC)) u_flags (
    .clk_i, .rst_ni,
    .set_i    (set_i),
    .sw_clr_i (sw_clr),
    .hw_clr_i (clr_i),
    .flag_o   (flags)
  );

  irq_enable_reg #(.N(N_SRC)) u_enables (
    .clk_i, .rst_ni,
    .we_i    (we_i && en_sel),
    .wdata_i (wdata_i),
    .en_o    (enables)
  );

  irq_line #(.N(N_SRC), .MASK(IRQ_SRC_MASK)) u_line (
    .clk_i, .rst_ni,
    .flag_i (flags),
    .en_i   (enables),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (flag_sel)    rdata_o = {pending, flags};
    else if (en_sel) rdata_o = {1'b1, enables};
  end

  a_r7_en_read_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_sel |-> rdata_o[DATA_W-1]);
  a_r11_other_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_sel && !en_sel) |-> (rdata_o == '0));
endmodule

// File: tb/irq_flag_enable_unit_tb.sv
module irq_flag_enable_unit_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [6:0] set_p = '0;
  logic [6:0] clr_p = '0;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_enable_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .set_i(set_p), .clr_i(clr_p), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, return at the following falling edge
  task automatic cycle(input logic w, input logic [3:0] a, input logic [7:0] d,
                       input logic [6:0] s, input logic [6:0] c);
    @(negedge clk);
    we = w; addr = a; wdata = d; set_p = s; clr_p = c;
    @(negedge clk);
    we = 1'b0; set_p = '0; clr_p = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(4'd13, v); check("R1 flags", v, 8'h00);
    rd(4'd14, v); check("R1 enables", v, 8'h80);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_enable_ops;
    logic [7:0] v;
    cycle(1, 4'd14, 8'hC4, 0, 0);
    rd(4'd14, v); check("R8 set", v, 8'hC4);
    cycle(1, 4'd14, 8'hA1, 0, 0);
    rd(4'd14, v); check("R8 set keeps others", v, 8'hE5);
    cycle(1, 4'd14, 8'h21, 0, 0);
    rd(4'd14, v); check("R9 clear", v, 8'hC4);
    cycle(1, 4'd14, 8'h00, 0, 0);
    rd(4'd14, v); check("R9 clear none", v, 8'hC4);
  endtask

  task automatic t_set_and_irq;
    logic [7:0] v;
    cycle(0, 4'd0, 0, 7'h04, 0);
    rd(4'd13, v); check("R2 set / R6 summary", v, 8'h84);
    check("R10 latency still low", {7'd0, irq}, 8'h00);
    @(negedge clk);
    check("R10 irq high", {7'd0, irq}, 8'h01);
    cycle(1, 4'd13, 8'hFB, 0, 0);
    rd(4'd13, v); check("R3 unselected kept", v, 8'h84);
    cycle(1, 4'd13, 8'h04, 0, 0);
    rd(4'd13, v); check("R3 clear", v, 8'h00);
    check("R10 irq still high one cycle", {7'd0, irq}, 8'h01);
    @(negedge clk);
    check("R10 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_timer2_and_summary;
    logic [7:0] v;
    cycle(1, 4'd14, 8'hA0, 0, 0);   // enable bit 5
    cycle(0, 4'd0, 0, 7'h20, 0);
    rd(4'd13, v); check("R6 bit5 summary", v, 8'hA0);
    @(negedge clk); @(negedge clk);
    check("R10 bit5 no irq", {7'd0, irq}, 8'h00);
    cycle(0, 4'd0, 0, 7'h01, 0);    // bit0 not enabled
    rd(4'd13, v); check("R6 summary", v, 8'hA1);
    cycle(1, 4'd14, 8'h20, 0, 0);
    rd(4'd13, v); check("R6 summary off", v, 8'h21);
    cycle(0, 4'd0, 0, 0, 7'h20);
    rd(4'd13, v); check("R4 hw clear", v, 8'h01);
  endtask

  task automatic t_priority;
    logic [7:0] v;
    cycle(1, 4'd13, 8'h01, 7'h01, 0);
    rd(4'd13, v); check("R5 set beats write", v, 8'h01);
    cycle(0, 4'd0, 0, 7'h40, 7'h41);
    rd(4'd13, v); check("R5 set beats clr / R4", v, 8'hC0);
    @(negedge clk);
    check("R10 timer1 irq", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_other_addr;
    logic [7:0] v;
    cycle(1, 4'd12, 8'hFF, 0, 0);
    cycle(1, 4'd15, 8'h7F, 0, 0);
    rd(4'd13, v); check("R11 flags kept", v, 8'hC0);
    rd(4'd14, v); check("R11 enables kept", v, 8'hC4);
    rd(4'd12, v); check("R11 other read", v, 8'h00);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_ops();
    t_set_and_irq();
    t_timer2_and_summary();
    t_priority();
    t_other_addr();
    finish_run();
  end
endmodule